// File: doc/BRIEF.md
# Quad-Channel Memory-Mapped Interval Timer

This block is a register-mapped timer with four identical up-counting channels. Each channel has its own terminal-count value, its own interrupt line and its own tick-enable input, so the channels can run at different rates. When a channel's counter matches its terminal count, the channel raises a pending flag. In continuous mode the counter restarts from zero. In one-shot mode the channel stops.

Software drives each channel through a 64-byte register bank. Reset, enable and disable are command addresses, and a write of any data to one of them performs the command. Mode, terminal count and interrupt enable are settable registers. Status, current count and terminal count can be read. A single clock-request bit, shared by all four channels, gates every counter. The bus is a simple single-cycle interface: writes are taken on the clock edge while the strobe is high, and read data is combinational from the address.

Top module: `quad_interval_timer`

## Requirements
- R1: After the asynchronous reset, every channel reads status 0x01 (idle), count 0 and terminal count 0xFFFFFFFF. All interrupt outputs are low, and the clock-request word at byte address 0x100 reads 0.
- R2: A channel's count goes up by exactly one on each clock edge at which the channel is running, the clock request is set and its tick input is high. In every other cycle the count holds.
- R3: In continuous mode (mode bit 0 = 0), a counting edge at which count equals terminal count sets the pending flag and loads zero into the count. The channel stays running, so a terminal count of N gives one event every N+1 ticks.
- R4: In one-shot mode (mode bit 0 = 1), a counting edge at which count equals terminal count sets the pending flag and stops the channel. The count stays at the terminal value, and further ticks have no effect.
- R5: The status word (bank offset 0x10) holds the state in bits [3:0], with 1 meaning idle and 2 meaning running. Bit 4 is set while the channel runs, bit 5 in one-shot mode, bit 6 while the interrupt is enabled and bit 7 while an event is pending. All other bits read 0.
- R6: A channel's interrupt output is high exactly while its pending flag is set and bit 0 of its interrupt-enable register (offset 0x1C) is 1.
- R7: A write to the acknowledge address (offset 0x20) clears the pending flag only if data bit 7 is 1. A write with bit 7 at 0 leaves the flag set.
- R8: A write of any data to the reset command (offset 0x00) sets the count to 0, makes the channel idle, clears the pending flag and returns the mode to continuous. It leaves the terminal count and the interrupt enable unchanged.
- R9: A write of any data to the enable command (offset 0x04) starts the channel, and a write of any data to the disable command (offset 0x08) stops it.
- R10: Channel k is decoded at byte address k*0x40. A write to one bank changes no other channel. The command, mode, enable and acknowledge addresses read back 0.
- R11: Bit 0 of the word at 0x100 is the shared clock request, and it reads back. While it is 0 no channel counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_i | input | 4 | Per-channel tick enable |
| irq_o | output | 4 | Per-channel interrupt |

## Verification
The assertions assume that a single address is accessed in each cycle, so at most one command hits a channel per edge. They also assume that software never acknowledges in the same edge on which a new terminal match occurs, since a new match outranks the acknowledge. The stimulus holds to both rules: it drives ticks only in bounded pulses, between register writes, and it never overlaps a pulse with a write. Reads are taken while all tick inputs are low, so each expected count follows only from the pulse lengths.

// File: rtl/qtm_pkg.sv
package qtm_pkg;
  localparam int BANK_LSB = 6;  // 64-byte bank per channel
  localparam int ACK_BIT  = 7;

  typedef enum logic [BANK_LSB-1:0] {
    OFF_RST  = 6'h00,
    OFF_EN   = 6'h04,
    OFF_DIS  = 6'h08,
    OFF_MODE = 6'h0C,
    OFF_STAT = 6'h10,
    OFF_CNT  = 6'h14,
    OFF_TC   = 6'h18,
    OFF_IE   = 6'h1C,
    OFF_ACK  = 6'h20
  } reg_off_e;

  localparam logic [3:0] ST_IDLE   = 4'd1;
  localparam logic [3:0] ST_ACTIVE = 4'd2;

  typedef struct packed {
    logic rst;
    logic en;
    logic dis;
    logic mode;
    logic tc;
    logic ie;
    logic ack;
  } ch_cmd_t;
endpackage

// File: rtl/qtm_decode.sv
module qtm_decode
  import qtm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  output ch_cmd_t [N_CH-1:0]       cmd_o,
  output logic                     creq_we_o
);
  localparam int CH_W = $clog2(N_CH);
  localparam int TOP  = BANK_LSB + CH_W;
  localparam logic [ADDR_W-1:0] CREQ_ADDR = ADDR_W'(N_CH << BANK_LSB);

  logic [CH_W-1:0]     bank;
  logic [BANK_LSB-1:0] off;
  logic                in_banks;

  assign bank      = addr_i[TOP-1:BANK_LSB];
  assign off       = addr_i[BANK_LSB-1:0];
  assign in_banks  = (addr_i[ADDR_W-1:TOP] == '0);
  assign creq_we_o = we_i && (addr_i == CREQ_ADDR);

  always_comb begin
    cmd_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (we_i && in_banks && bank == CH_W'(k)) begin
        case (off)
          OFF_RST:  cmd_o[k].rst  = 1'b1;
          OFF_EN:   cmd_o[k].en   = 1'b1;
          OFF_DIS:  cmd_o[k].dis  = 1'b1;
          OFF_MODE: cmd_o[k].mode = 1'b1;
          OFF_TC:   cmd_o[k].tc   = 1'b1;
          OFF_IE:   cmd_o[k].ie   = 1'b1;
          OFF_ACK:  cmd_o[k].ack  = 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/qtm_channel.sv
module qtm_channel
  import qtm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  ch_cmd_t          cmd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] tc_o,
  output logic [7:0]       stat_o,
  output logic             irq_o
);
  logic             run_q, mode_q, ie_q, pend_q;
  logic [CNT_W-1:0] cnt_q, tc_q;
  logic             step, hit;

  assign step = run_q && adv_i;
  assign hit  = step && (cnt_q == tc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      tc_q   <= '1;
    end else begin
      if (step) begin
        if (!hit)        cnt_q <= cnt_q + 1'b1;
        else if (!mode_q) cnt_q <= '0;
        if (hit && mode_q) run_q <= 1'b0;
      end
      if (cmd_i.ack && wdata_i[ACK_BIT]) pend_q <= 1'b0;
      if (hit)        pend_q <= 1'b1;  // new event outranks ack
      if (cmd_i.en)   run_q  <= 1'b1;
      if (cmd_i.dis)  run_q  <= 1'b0;
      if (cmd_i.mode) mode_q <= wdata_i[0];
      if (cmd_i.tc)   tc_q   <= wdata_i;
      if (cmd_i.ie)   ie_q   <= wdata_i[0];
      if (cmd_i.rst) begin
        cnt_q  <= '0;
        run_q  <= 1'b0;
        pend_q <= 1'b0;
        mode_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign tc_o   = tc_q;
  assign stat_o = {pend_q, ie_q, mode_q, run_q, run_q ? ST_ACTIVE : ST_IDLE};
  assign irq_o  = pend_q & ie_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !cmd_i.rst) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !hit && !cmd_i.rst) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !mode_q && !cmd_i.rst) |=> (cnt_q == '0) && pend_q && run_q);
  p_oneshot_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && mode_q && !cmd_i.rst && !cmd_i.en) |=> !run_q && pend_q && $stable(cnt_q));
  p_rst_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.rst |=> (cnt_q == '0) && !run_q && !pend_q && !mode_q && $stable(tc_q));
  p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.ack && wdata_i[ACK_BIT] && !hit) |=> !pend_q && !irq_o);
endmodule

// File: rtl/qtm_rdmux.sv
module qtm_rdmux
  import qtm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  cnt_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  tc_i,
  input  logic [N_CH-1:0][7:0]        stat_i,
  input  logic                        creq_i,
  output logic [CNT_W-1:0]            rdata_o
);
  localparam int CH_W = $clog2(N_CH);
  localparam int TOP  = BANK_LSB + CH_W;
  localparam logic [ADDR_W-1:0] CREQ_ADDR = ADDR_W'(N_CH << BANK_LSB);

  logic [CH_W-1:0]     bank;
  logic [BANK_LSB-1:0] off;

  assign bank = addr_i[TOP-1:BANK_LSB];
  assign off  = addr_i[BANK_LSB-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1:TOP] == '0) begin
      case (off)
        OFF_STAT: rdata_o = CNT_W'(stat_i[bank]);
        OFF_CNT:  rdata_o = cnt_i[bank];
        OFF_TC:   rdata_o = tc_i[bank];
        default:  rdata_o = '0;  // command and write-only addresses
      endcase
    end else if (addr_i == CREQ_ADDR) begin
      rdata_o = CNT_W'(creq_i);
    end
  end
endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
  import qtm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   tick_i,
  output logic [N_CH-1:0]   irq_o
);
  ch_cmd_t [N_CH-1:0]          cmd;
  logic                        creq_we, creq_q;
  logic [N_CH-1:0][CNT_W-1:0]  cnt, tc;
  logic [N_CH-1:0][7:0]        stat;

  qtm_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .cmd_o    (cmd),
    .creq_we_o(creq_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      creq_q <= 1'b0;
    else if (creq_we) creq_q <= wdata_i[0];
  end

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    qtm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (tick_i[k] & creq_q),
      .cmd_i  (cmd[k]),
      .wdata_i(wdata_i),
      .cnt_o  (cnt[k]),
      .tc_o   (tc[k]),
      .stat_o (stat[k]),
      .irq_o  (irq_o[k])
    );

    p_creq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!creq_q && !cmd[k].rst) |=> $stable(cnt[k]));
  end

  qtm_rdmux #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i (addr_i),
    .cnt_i  (cnt),
    .tc_i   (tc),
    .stat_i (stat),
    .creq_i (creq_q),
    .rdata_o(rdata_o)
  );
endmodule

// File: tb/quad_interval_timer_test.sv
module quad_interval_timer_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  tick_i = '0;
  logic [3:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } chk_t;
  chk_t q[$];

  always #4 clk_i = ~clk_i;  // 125 MHz

  quad_interval_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .irq_o(irq_o)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        chk_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {28'b0, irq_o} : rdata_o;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    chk_t it;
    @(negedge clk_i);
    addr_i = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic irq_chk(input logic [3:0] e, input string tag);
    chk_t it;
    @(negedge clk_i);
    #1;
    it.is_irq = 1'b1; it.exp = {28'b0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // tick high for exactly n rising edges
  task automatic pulse(input logic [3:0] m, input int n);
    @(negedge clk_i);
    tick_i = m;
    repeat (n) @(posedge clk_i);
    #1 tick_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      rd(9'(k * 64 + 16), 32'h01, "R1 status after reset");
      rd(9'(k * 64 + 20), 32'h0, "R1 count after reset");
      rd(9'(k * 64 + 24), 32'hFFFF_FFFF, "R1 terminal after reset");
    end
    rd(9'h100, 32'h0, "R1 clock request after reset");
    irq_chk(4'h0, "R1 irq after reset");

    // R10 write-only reads zero
    wr(9'h00C, 32'h1);
    rd(9'h00C, 32'h0, "R10 mode reads zero");
    wr(9'h00C, 32'h0);

    // R11 no counting without clock request; R9 enable; R5 running status
    wr(9'h004, 32'h0);
    pulse(4'h1, 4);
    rd(9'h014, 32'h0, "R11 no count while request off");
    rd(9'h010, 32'h12, "R5 R9 running status");

    wr(9'h100, 32'h1);
    rd(9'h100, 32'h1, "R11 request reads back");
    pulse(4'hF, 3);
    rd(9'h014, 32'd3, "R2 counts ticks");
    rd(9'h054, 32'd0, "R2 stopped channel holds");

    // R3 continuous wrap, R6 irq
    wr(9'h018, 32'd5);
    wr(9'h01C, 32'h1);
    pulse(4'h1, 2);
    rd(9'h014, 32'd5, "R2 count at terminal");
    rd(9'h010, 32'h52, "R5 no pending before match");
    pulse(4'h1, 1);
    rd(9'h014, 32'd0, "R3 wrap to zero");
    rd(9'h010, 32'hD2, "R3 R5 pending running");
    irq_chk(4'h1, "R6 irq asserted");
    pulse(4'h1, 6);
    rd(9'h014, 32'd0, "R3 second period");

    // R7 acknowledge
    wr(9'h020, 32'h01);
    rd(9'h010, 32'hD2, "R7 ack without bit7 ignored");
    wr(9'h020, 32'h80);
    rd(9'h010, 32'h52, "R7 ack clears pending");
    irq_chk(4'h0, "R6 irq low after ack");

    // R6 masked interrupt
    wr(9'h01C, 32'h0);
    pulse(4'h1, 6);
    rd(9'h010, 32'h92, "R6 pending with irq disabled");
    irq_chk(4'h0, "R6 irq masked");
    wr(9'h020, 32'h80);

    // R9 disable with arbitrary data
    pulse(4'h1, 2);
    wr(9'h008, 32'h0000_DEAD);
    pulse(4'h1, 3);
    rd(9'h014, 32'd2, "R9 disabled count holds");
    rd(9'h010, 32'h01, "R9 idle after disable");

    // R4 one-shot on channel 2
    wr(9'h08C, 32'h1);
    wr(9'h098, 32'd3);
    wr(9'h09C, 32'h1);
    wr(9'h084, 32'hFFFF_FFFF);
    pulse(4'h4, 3);
    rd(9'h094, 32'd3, "R4 count reached terminal");
    rd(9'h090, 32'h72, "R5 one-shot running status");
    pulse(4'h4, 1);
    rd(9'h090, 32'hE1, "R4 stopped with pending");
    irq_chk(4'h4, "R4 R6 one-shot irq");
    pulse(4'h4, 5);
    rd(9'h094, 32'd3, "R4 count held after stop");

    // R8 reset command
    wr(9'h080, 32'h0000_1234);
    rd(9'h094, 32'd0, "R8 count cleared");
    rd(9'h090, 32'h41, "R8 idle continuous ie kept");
    rd(9'h098, 32'd3, "R8 terminal kept");
    irq_chk(4'h0, "R8 irq cleared");

    // R10 bank isolation
    rd(9'h058, 32'hFFFF_FFFF, "R10 channel1 terminal untouched");
    rd(9'h050, 32'h01, "R10 channel1 status untouched");
    rd(9'h0D0, 32'h01, "R10 channel3 status untouched");
    rd(9'h014, 32'd2, "R10 channel0 count untouched");

    // free-running channel 3, then R11 gating again
    wr(9'h0C4, 32'h0);
    pulse(4'h8, 7);
    rd(9'h0D4, 32'd7, "R2 free-running count");
    wr(9'h100, 32'h0);
    pulse(4'h8, 4);
    rd(9'h0D4, 32'd7, "R11 request cleared stops count");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule